// File: doc/BRIEF.md
# Table-Driven 16-QAM Carrier Synthesiser

This block produces a digital 16-level quadrature amplitude modulated carrier as a stream of 7-bit offset-binary samples. A phase counter steps through a twelve-entry sine table at 30-degree intervals, one step per clock enable. The same table, read three entries ahead, supplies the cosine. The two carriers are centred around zero, and each one is weighted by one of four signed levels chosen by two symbol bits. The weighted carriers are summed, halved, and shifted back to mid-scale, so the result fits a 7-bit converter.

Each 4-bit symbol comes from one of two sources. In sample mode, an 8-bit sample is captured and sent over two carrier periods, low nibble first. In direct mode, a 4-bit symbol input is used as it stands. A new symbol takes effect only when the phase counter wraps, so each symbol occupies whole carrier periods.

Top module: `qam16_mod`

## Requirements
- R1: While rst_n is low, at the clock edge the output becomes 0x40, the phase becomes 0, the symbol becomes 0000 and the nibble order returns to low-first.
- R2: The phase advances by one on every clock edge with tickEn high, holds when tickEn is low, and wraps from 11 to 0.
- R3: The sine table entry for phase n is 0x3F*sin(30n deg)+0x40, rounded to the nearest integer: 0x40,0x60,0x77,0x7F,0x77,0x60,0x40,0x20,0x09,0x01,0x09,0x20 for n=0..11.
- R4: The cosine for phase n is the table entry at (n+3) mod 12.
- R5: Each axis is centred by subtracting 0x40. Its two-bit level code then scales it: 00 gives -x, 01 gives -floor(x/2), 10 gives floor(x/2), 11 gives x.
- R6: Symbol bits [3:2] select the level for the cosine (I) axis, and bits [1:0] select the level for the sine (Q) axis.
- R7: On every clock edge, qamOut takes floor((I+Q)/2)+0x40, computed from the phase and symbol held before that edge. qamOut always lies in 1..127.
- R8: The symbol changes only on a clock edge where tickEn is high and the phase is 11.
- R9: In sample mode (useDirect=0), a wrap that sends a low nibble captures sampleIn and sends bits [3:0]. The next wrap sends bits [7:4] of the captured value. A change on sampleIn between those two wraps has no effect on what is sent.
- R10: In direct mode (useDirect=1), each wrap loads directSym and resets the nibble order, so the next wrap in sample mode sends a low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tickEn | input | 1 | Phase step enable |
| useDirect | input | 1 | 1 selects directSym as the symbol source, 0 selects the sample |
| directSym | input | 4 | Directly set symbol |
| sampleIn | input | 8 | Sample sent as two nibbles |
| qamOut | output | 7 | Offset-binary modulated sample |

## Verification
Every result is due one clock edge after the phase and symbol state it depends on. The symbol itself settles on the wrap edge, so the first output sample to carry a new symbol appears two edges after the enable that closes phase 11. The bench drives inputs and samples the output on falling edges. For each cycle it computes the expected sample from its own model of phase, symbol and nibble order as they stood before the next rising edge, and compares it on the falling edge that follows. Directed full-period sweeps of all sixteen symbols are followed by random enable gaps and random switching between the two sources, including sample changes between the two halves of a sample.

// File: rtl/qam16_pkg.sv
package qam16_pkg;
  localparam int TABLE_LEN = 12;
  localparam int QUARTER   = TABLE_LEN / 4;
  localparam int PH_W      = $clog2(TABLE_LEN);
  localparam int SYM_W     = 4;
  localparam int SAMPLE_W  = 2 * SYM_W;
  localparam int OUT_W     = 7;
  localparam int MID       = 1 << (OUT_W - 1);
  localparam int CW        = OUT_W + 1;

  typedef struct packed {
    logic [PH_W-1:0] phase;
    logic [1:0]      iLevel;
    logic [1:0]      qLevel;
  } qamCtl_t;

  function automatic logic [OUT_W-1:0] sineEntry(input logic [PH_W-1:0] idx);
    case (idx)
      4'd0:    sineEntry = 7'h40;
      4'd1:    sineEntry = 7'h60;
      4'd2:    sineEntry = 7'h77;
      4'd3:    sineEntry = 7'h7F;
      4'd4:    sineEntry = 7'h77;
      4'd5:    sineEntry = 7'h60;
      4'd6:    sineEntry = 7'h40;
      4'd7:    sineEntry = 7'h20;
      4'd8:    sineEntry = 7'h09;
      4'd9:    sineEntry = 7'h01;
      4'd10:   sineEntry = 7'h09;
      default: sineEntry = 7'h20;
    endcase
  endfunction

  function automatic logic signed [CW-1:0] scaleAxis(input logic signed [CW-1:0] v,
                                                     input logic [1:0] lvl);
    logic signed [CW-1:0] half;
    half = v >>> 1;
    case (lvl)
      2'b11:   scaleAxis = v;
      2'b10:   scaleAxis = half;
      2'b01:   scaleAxis = -half;
      default: scaleAxis = -v;
    endcase
  endfunction
endpackage

// File: rtl/qam16_ctrl.sv
module qam16_ctrl
  import qam16_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tickEn,
  input  logic                useDirect,
  input  logic [SYM_W-1:0]    directSym,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output qamCtl_t             ctl
);
  localparam logic [PH_W-1:0] LAST = PH_W'(TABLE_LEN - 1);

  logic [PH_W-1:0]     phase;
  logic [SYM_W-1:0]    symbol;
  logic [SAMPLE_W-1:0] sampleReg;
  logic                nibHigh;
  logic                wrap;

  assign wrap = tickEn && (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      symbol    <= '0;
      sampleReg <= '0;
      nibHigh   <= 1'b0;
    end else if (tickEn) begin
      if (wrap) begin
        phase <= '0;
        if (useDirect) begin
          symbol  <= directSym;
          nibHigh <= 1'b0;
        end else if (!nibHigh) begin
          sampleReg <= sampleIn;
          symbol    <= sampleIn[SYM_W-1:0];
          nibHigh   <= 1'b1;
        end else begin
          symbol  <= sampleReg[SAMPLE_W-1:SYM_W];
          nibHigh <= 1'b0;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign ctl.phase  = phase;
  assign ctl.iLevel = symbol[3:2];
  assign ctl.qLevel = symbol[1:0];

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);
  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tickEn |=> $stable(phase));
  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && phase == LAST) |=> phase == '0);
  assert_symbol_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tickEn && phase == LAST) |=> $stable(symbol));
  assert_direct_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && phase == LAST && useDirect) |=> (symbol == $past(directSym) && !nibHigh));
endmodule

// File: rtl/qam16_datapath.sv
module qam16_datapath
  import qam16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  qamCtl_t          ctl,
  output logic [OUT_W-1:0] qamOut
);
  logic [PH_W-1:0]       cosIdx;
  logic signed [CW-1:0]  sinC, cosC, iPart, qPart;
  logic signed [CW:0]    sum, outWide;

  assign cosIdx = (ctl.phase >= PH_W'(TABLE_LEN - QUARTER))
                  ? ctl.phase - PH_W'(TABLE_LEN - QUARTER)
                  : ctl.phase + PH_W'(QUARTER);

  assign sinC    = $signed({1'b0, sineEntry(ctl.phase)}) - CW'(MID);
  assign cosC    = $signed({1'b0, sineEntry(cosIdx)}) - CW'(MID);
  assign iPart   = scaleAxis(cosC, ctl.iLevel);
  assign qPart   = scaleAxis(sinC, ctl.qLevel);
  assign sum     = (CW+1)'(iPart) + (CW+1)'(qPart);
  assign outWide = (sum >>> 1) + (CW+1)'(MID);

  always_ff @(posedge clk) begin
    if (!rst_n) qamOut <= OUT_W'(MID);
    else        qamOut <= outWide[OUT_W-1:0];
  end

  assert_out_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    qamOut != '0);
  assert_axis_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iPart <= CW'(MID - 1)) && (iPart >= -CW'(MID - 1)));
endmodule

// File: rtl/qam16_mod.sv
module qam16_mod
  import qam16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic       useDirect,
  input  logic [3:0] directSym,
  input  logic [7:0] sampleIn,
  output logic [6:0] qamOut
);
  qamCtl_t ctl;

  qam16_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .useDirect(useDirect),
    .directSym(directSym), .sampleIn(sampleIn), .ctl(ctl)
  );

  qam16_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .qamOut(qamOut)
  );
endmodule

// File: tb/qam16_mod_test.sv
`timescale 1ns/1ps
module qam16_mod_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickEn = 1'b0, useDirect = 1'b1;
  logic [3:0] directSym = '0;
  logic [7:0] sampleIn = '0;
  logic [6:0] qamOut;

  int checks = 0, errors = 0;
  int mPh = 0, mSym = 0, mNib = 0, mReg = 0, expV = 64;
  string tagNow = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  qam16_mod uut (.clk(clk), .rst_n(rst_n), .tickEn(tickEn), .useDirect(useDirect),
                 .directSym(directSym), .sampleIn(sampleIn), .qamOut(qamOut));

  // R3 sine table
  function automatic int tbl(int n);
    case (n)
      0: return 64;  1: return 96;  2: return 119; 3: return 127;
      4: return 119; 5: return 96;  6: return 64;  7: return 32;
      8: return 9;   9: return 1;   10: return 9;  default: return 32;
    endcase
  endfunction

  // R5 level mapping
  function automatic int lvl(int v, int b);
    int h;
    h = v >>> 1;
    case (b)
      3: return v;
      2: return h;
      1: return -h;
      default: return -v;
    endcase
  endfunction

  // R4 R6 R7 output model
  function automatic int expOut(int ph, int sym);
    int c, s, sum;
    c = tbl((ph + 3) % 12) - 64;
    s = tbl(ph) - 64;
    sum = lvl(c, (sym >> 2) & 3) + lvl(s, sym & 3);
    return (sum >>> 1) + 64;
  endfunction

  task automatic check(int act, int exp_v, string tag);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp_v, $time);
    end
  endtask

  // R2 R8 R9 R10 model update
  task automatic step(bit te, bit ud, int ds, int si);
    @(negedge clk);
    check(int'(qamOut), expV, tagNow);
    tickEn = te; useDirect = ud; directSym = 4'(ds); sampleIn = 8'(si);
    expV = expOut(mPh, mSym);
    if (te) begin
      if (mPh == 11) begin
        mPh = 0;
        if (ud) begin mSym = ds; mNib = 0; end
        else if (mNib == 0) begin mReg = si; mSym = si & 15; mNib = 1; end
        else begin mSym = (mReg >> 4) & 15; mNib = 0; end
      end else mPh++;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(int'(qamOut), 64, "R1 reset output");
    @(negedge clk);
    rst_n = 1'b1;
    expV = expOut(0, 0);

    // R1: first period after reset runs with symbol 0000
    tagNow = "R1 R2 R7";
    for (int k = 0; k < 12; k++) step(1, 1, 5, 0);

    // R3 R4 R5 R6 R7: every symbol for full periods
    tagNow = "R3 R4 R5 R6 R7";
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 12; k++) step(1, 1, (s + 1) % 16, 0);
    for (int k = 0; k < 24; k++) step(1, 1, 15, 0);

    // R2 R8: gapped enables, directSym changing mid-period
    tagNow = "R2 R8";
    for (int k = 0; k < 2000; k++)
      step(($urandom % 3) != 0, 1, $urandom % 16, $urandom % 256);

    // R9: sample mode, sampleIn changed between nibbles
    tagNow = "R9";
    for (int k = 0; k < 48; k++) step(1, 0, 0, (k < 12) ? 8'hA5 : $urandom % 256);
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, 0, $urandom % 16, $urandom % 256);

    // R10: switching sources resets nibble order
    tagNow = "R10";
    for (int k = 0; k < 4000; k++)
      step(($urandom % 4) != 0, ($urandom % 5) == 0, $urandom % 16, $urandom % 256);

    tagNow = "R7 drain";
    for (int k = 0; k < 4; k++) step(0, 1, 0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule